// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures one frequency component of a block of ADC data. It does not compute a full transform. It correlates a block of 2048 signed 16-bit samples against a cosine and a sine at the excitation frequency. The result is the real and imaginary parts of that single bin. The bin is selected by the same 24-bit frequency control word that sets the sine excitation generator. The measured response therefore stays locked to the stimulus without any extra configuration.

Software pulses `start_i` with the control word on `fcw_i`. It then streams samples with a valid qualifier. The block keeps an internal phase that steps by the captured word once per accepted sample. The top bits of that phase address a quarter-wave sine table, which supplies both the cosine and the sine. Two multiply-accumulate lanes build the sums. When the last sample of the block has been taken, a one-cycle `done_o` pulse marks both results valid. The results then hold until the next start. Magnitude and phase are derived by software.

Top module: `dft_bin_correlator`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, and `re_o` and `im_o` are 0.
- R2: A cycle with `start_i` high clears both results and the phase, and raises `busy_o` on the next edge. A sample presented in the start cycle is not accumulated. A start while a transform is running abandons it and begins a new one.
- R3: A sample is accepted only when `sample_valid_i` is high, `busy_o` is high and `start_i` is low. After exactly 2048 accepted samples, `busy_o` falls and `done_o` is high for exactly one cycle. Both take effect at the edge that accepts the final sample.
- R4: Accepted sample n (counting from 0) uses phase P = (n·F) mod 2^24, where F is `fcw_i` captured at start. The table address A is the top 10 bits of P, that is P >> 14.
- R5: Let T(k) = floor(4·k·(512−k)·32767 / (327680 − k·(512−k))) for k in 0..256. Let a = A mod 256. The sine at address A is T(a) for A in 0..255, T(256−a) for A in 256..511, −T(a) for A in 512..767, and −T(256−a) for A in 768..1023. The cosine at A is the sine at (A+256) mod 1024.
- R6: `re_o` = Σ x·cos(A) and `im_o` = −Σ x·sin(A). Both are signed 43-bit two's-complement values. They are exact for all inputs, including a full block of −32768 samples.
- R7: Once a transform has finished, the results hold until the next start. Samples arriving while `busy_o` is low do not change them.
- R8: Cycles with `sample_valid_i` low during a transform do not change the results, the sample count or the phase.
- R9: Changes on `fcw_i` after the start cycle have no effect on the running transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new transform and capture the control word |
| fcw_i | input | 24 | Frequency control word shared with the excitation generator |
| sample_valid_i | input | 1 | Qualifies `sample_i` |
| sample_i | input | 16 | Signed ADC sample |
| busy_o | output | 1 | A transform is in progress |
| done_o | output | 1 | One-cycle pulse: results just completed |
| re_o | output | 43 | Signed real part of the bin |
| im_o | output | 43 | Signed imaginary part of the bin |

## Verification
The bench builds two instances from the same stimulus. One uses the default 2048-sample block length. The other uses a 64-sample block (block-length exponent 6), and both keep the 24-bit phase and 10-bit table address. The short instance completes and must then stay idle while the long one keeps consuming samples. This brings the ignore-while-idle behaviour and the exact position of the done pulse into reach many times per run. The default instance reaches the full-scale accumulation limit and the control-word extremes of 0 and 0xFFFFFF.

// File: rtl/dft_pkg.sv
package dft_pkg;

    // Integer rational sine approximation on a quarter wave.
    // k runs over 0..half/2, half is the table size of a half period,
    // amp the full-scale coefficient value.
    function automatic longint bhaskara_sine(input int k, input int half, input int amp);
        longint t;
        longint den;
        t   = longint'(k) * longint'(half - k);
        den = (longint'(5) * longint'(half) * longint'(half)) / 4 - t;
        return (longint'(4) * t * longint'(amp)) / den;
    endfunction

endpackage

// File: rtl/dft_phase_gen.sv
module dft_phase_gen #(
    parameter int PHASE_W    = 24,
    parameter int LUT_ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  step_i,
    input  logic [PHASE_W-1:0]    fcw_i,
    output logic [LUT_ADDR_W-1:0] addr_o
);

    logic [PHASE_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (clear_i) begin
            phase_d = '0;
        end else if (step_i) begin
            phase_d = phase_q + fcw_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign addr_o = phase_q[PHASE_W-1 -: LUT_ADDR_W];

endmodule

// File: rtl/dft_trig_lut.sv
module dft_trig_lut #(
    parameter int LUT_ADDR_W = 10,
    parameter int COEF_W     = 16
) (
    input  logic [LUT_ADDR_W-1:0]     addr_i,
    output logic signed [COEF_W-1:0]  cos_o,
    output logic signed [COEF_W-1:0]  sin_o
);

    localparam int QN     = 2 ** (LUT_ADDR_W - 2);
    localparam int HALF   = 2 ** (LUT_ADDR_W - 1);
    localparam int AMP    = 2 ** (COEF_W - 1) - 1;
    localparam int IDX_W  = LUT_ADDR_W - 1;

    logic signed [COEF_W-1:0] tbl [0:QN];

    for (genvar g = 0; g <= QN; g++) begin : g_tbl
        assign tbl[g] = COEF_W'(dft_pkg::bhaskara_sine(g, HALF, AMP));
    end

    function automatic logic signed [COEF_W-1:0] quad_sine(input logic [LUT_ADDR_W-1:0] a);
        logic [IDX_W-1:0]         off;
        logic [IDX_W-1:0]         idx;
        logic signed [COEF_W-1:0] mag;
        off = {1'b0, a[LUT_ADDR_W-3:0]};
        if (a[LUT_ADDR_W-2]) begin
            idx = IDX_W'(QN) - off;
        end else begin
            idx = off;
        end
        mag = tbl[idx];
        if (a[LUT_ADDR_W-1]) begin
            return -mag;
        end
        return mag;
    endfunction

    logic [LUT_ADDR_W-1:0] cos_addr;

    always_comb begin
        cos_addr = addr_i + LUT_ADDR_W'(QN);
        sin_o    = quad_sine(addr_i);
        cos_o    = quad_sine(cos_addr);
    end

endmodule

// File: rtl/dft_mac_lane.sv
module dft_mac_lane #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 43,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       en_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [COEF_W-1:0]   coef_i,
    output logic signed [ACC_W-1:0]    acc_o
);

    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_d, acc_q;

    always_comb begin
        prod     = PROD_W'(sample_i) * PROD_W'(coef_i);
        prod_ext = ACC_W'(prod);
        acc_d    = acc_q;
        if (clear_i) begin
            acc_d = '0;
        end else if (en_i) begin
            if (SUBTRACT) begin
                acc_d = acc_q - prod_ext;
            end else begin
                acc_d = acc_q + prod_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/dft_bin_correlator.sv
module dft_bin_correlator #(
    parameter int SAMPLE_W   = 16,
    parameter int COEF_W     = 16,
    parameter int PHASE_W    = 24,
    parameter int LUT_ADDR_W = 10,
    parameter int N_LOG2     = 11
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [PHASE_W-1:0]                    fcw_i,
    input  logic                                  sample_valid_i,
    input  logic [SAMPLE_W-1:0]                   sample_i,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic [SAMPLE_W+COEF_W+N_LOG2-1:0]     re_o,
    output logic [SAMPLE_W+COEF_W+N_LOG2-1:0]     im_o
);

    localparam int ACC_W = SAMPLE_W + COEF_W + N_LOG2;
    localparam logic [N_LOG2-1:0] LAST = '1;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [N_LOG2-1:0]  cnt;
        logic [PHASE_W-1:0] fcw;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  accept;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        accept      = ctrl_q.busy && sample_valid_i && !start_i;
        if (start_i) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.cnt  = '0;
            ctrl_d.fcw  = fcw_i;
        end else if (accept) begin
            ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            if (ctrl_q.cnt == LAST) begin
                ctrl_d.busy = 1'b0;
                ctrl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    logic [LUT_ADDR_W-1:0]    lut_addr;
    logic signed [COEF_W-1:0] cos_v, sin_v;
    logic signed [ACC_W-1:0]  re_acc, im_acc;

    dft_phase_gen #(
        .PHASE_W    (PHASE_W),
        .LUT_ADDR_W (LUT_ADDR_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (accept),
        .fcw_i   (ctrl_q.fcw),
        .addr_o  (lut_addr)
    );

    dft_trig_lut #(
        .LUT_ADDR_W (LUT_ADDR_W),
        .COEF_W     (COEF_W)
    ) u_lut (
        .addr_i (lut_addr),
        .cos_o  (cos_v),
        .sin_o  (sin_v)
    );

    dft_mac_lane #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W),
        .SUBTRACT (1'b0)
    ) u_mac_re (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .en_i     (accept),
        .sample_i (sample_i),
        .coef_i   (cos_v),
        .acc_o    (re_acc)
    );

    dft_mac_lane #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W),
        .SUBTRACT (1'b1)
    ) u_mac_im (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .en_i     (accept),
        .sample_i (sample_i),
        .coef_i   (sin_v),
        .acc_o    (im_acc)
    );

    assign busy_o = ctrl_q.busy;
    assign done_o = ctrl_q.done;
    assign re_o   = re_acc;
    assign im_o   = im_acc;

endmodule

// File: rtl/dft_bin_correlator_chk.sv
module dft_bin_correlator_chk #(
    parameter int N_LOG2 = 11,
    parameter int ACC_W  = 43
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sample_valid_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [ACC_W-1:0] re_o,
    input logic [ACC_W-1:0] im_o
);

    localparam logic [N_LOG2:0] N_SAMPLES = (N_LOG2+1)'(2 ** N_LOG2);

    logic [N_LOG2:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (start_i) begin
            seen_q <= '0;
        end else if (busy_o && sample_valid_i) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && re_o == '0 && im_o == '0)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3
    AST_DONE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seen_q == N_SAMPLES)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(re_o) && $stable(im_o))); // R7
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sample_valid_i && !start_i) |=> ($stable(re_o) && $stable(im_o))); // R8

endmodule

bind dft_bin_correlator dft_bin_correlator_chk #(
    .N_LOG2 (N_LOG2),
    .ACC_W  (ACC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sample_valid_i (sample_valid_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .re_o           (re_o),
    .im_o           (im_o)
);

// File: tb/dft_bin_correlator_tb.sv
module dft_bin_correlator_tb;

    localparam int NL = 2048;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] fcw = '0;
    logic        valid = 1'b0;
    logic [15:0] sample = '0;

    logic               busy_l, done_l, busy_s, done_s;
    logic signed [42:0] re_l, im_l;
    logic signed [36:0] re_s, im_s;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dft_bin_correlator u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fcw_i(fcw),
        .sample_valid_i(valid), .sample_i(sample),
        .busy_o(busy_l), .done_o(done_l), .re_o(re_l), .im_o(im_l)
    );

    dft_bin_correlator #(.N_LOG2(6)) u_short (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fcw_i(fcw),
        .sample_valid_i(valid), .sample_i(sample),
        .busy_o(busy_s), .done_o(done_s), .re_o(re_s), .im_o(im_s)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5 table entry
    function automatic longint tab(input int k);
        longint t;
        t = longint'(k) * longint'(512 - k);
        return (longint'(4) * t * 32767) / (longint'(327680) - t);
    endfunction

    function automatic longint sin_ref(input int a);
        int m;
        m = a % 256;
        case (a / 256)
            0: return tab(m);
            1: return tab(256 - m);
            2: return -tab(m);
            default: return -tab(256 - m);
        endcase
    endfunction

    function automatic longint cos_ref(input int a);
        return sin_ref((a + 256) % 1024);
    endfunction

    function automatic logic [15:0] gen(input int pat, input int n);
        case (pat)
            1: return 16'h8000;
            2: return 16'h7fff;
            3: return (n % 2 == 0) ? 16'h7fff : 16'h8000;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic run_block(input logic [23:0] f, input int pat, input int gap, input int stop_after);
        longint er_l = 0, ei_l = 0, er_s = 0, ei_s = 0;
        int n = 0;
        logic v;
        logic [15:0] s;
        longint x, p;
        int a;
        @(negedge clk);
        start = 1'b1; fcw = f; valid = 1'b1; sample = 16'h7fff;
        @(negedge clk);
        start = 1'b0; valid = 1'b0;
        chk("R2 busy after start", longint'(busy_l), 1);
        chk("R2 re cleared, start-cycle sample dropped", longint'(re_l), 0);
        chk("R2 im cleared", longint'(im_l), 0);
        while (n < NL) begin
            if (stop_after > 0 && n == stop_after) return;
            v = (($urandom % 100) >= gap);
            s = gen(pat, n);
            valid = v; sample = s;
            fcw = 24'($urandom); // R9: ignored while running
            if (v) begin
                x = longint'($signed(s));
                p = (longint'(n) * longint'(f)) % 64'd16777216;
                a = int'(p >> 14); // R4
                er_l += x * cos_ref(a);
                ei_l -= x * sin_ref(a);
                if (n < NS) begin
                    er_s += x * cos_ref(a);
                    ei_s -= x * sin_ref(a);
                end
                n++;
            end
            @(negedge clk);
            if (done_l != (v && n == NL))
                chk("R3 done timing long", longint'(done_l), longint'(v && n == NL));
            if (done_s != (v && n == NS))
                chk("R3 done timing short", longint'(done_s), longint'(v && n == NS));
            if (v && n == NS) begin
                chk("R3 short done pulse", longint'(done_s), 1);
                chk("R3 short busy fell", longint'(busy_s), 0);
                chk("R6 short real", longint'(re_s), er_s);
                chk("R6 short imag", longint'(im_s), ei_s);
            end
        end
        chk("R3 long done pulse", longint'(done_l), 1);
        chk("R3 long busy fell", longint'(busy_l), 0);
        chk("R6 R4 R5 R8 R9 long real", longint'(re_l), er_l);
        chk("R6 R4 R5 R8 R9 long imag", longint'(im_l), ei_l);
        valid = 1'b1; sample = 16'($urandom);
        @(negedge clk);
        chk("R3 done one cycle only", longint'(done_l), 0);
        chk("R7 real held while idle", longint'(re_l), er_l);
        chk("R7 imag held while idle", longint'(im_l), ei_l);
        chk("R7 short real held", longint'(re_s), er_s);
        valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", longint'(busy_l), 0);
        chk("R1 done at reset", longint'(done_l), 0);
        chk("R1 real at reset", longint'(re_l), 0);
        chk("R1 imag at reset", longint'(im_l), 0);
        rst_n = 1'b1;
        @(negedge clk);
        valid = 1'b1; sample = 16'h1234;
        @(negedge clk);
        valid = 1'b0;
        chk("R7 idle sample before start ignored", longint'(re_l), 0);
        chk("R1 busy stays low", longint'(busy_l), 0);

        run_block(24'h000000, 1, 0, 0);   // R6 full-scale DC
        run_block(24'd40960, 0, 25, 0);   // bin 5, gaps R8
        run_block(24'hFFFFFF, 3, 10, 0);  // max control word
        run_block(24'($urandom), 0, 40, 700);
        run_block(24'h400000, 2, 0, 0);   // R2 restart while busy
        run_block(24'($urandom), 0, 15, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule